// File: doc/BRIEF.md
# Stop Mode Wake Recovery Timer

This block times the settling delay that follows a low-power stop state, so that the clock source is stable before the processor continues. An accepted stop request clears a free-running cycle counter and freezes it. Any one of three wake sources ends the stop: an interrupt, a break or an external reset. At that moment a short-recovery configuration bit is captured. It selects either a short delay of 32 oscillator cycles, which suits canned oscillators, or a long delay of 4096 cycles, which suits crystals that start slowly.

While the delay runs, a recovery flag is high. A single-cycle done pulse marks the last recovery cycle and lets execution resume. Outside stop the counter keeps running and wraps. External reset never clears or alters the count. A power-on reset is the only thing that initialises the block.

Top module: `stop_recov_timer`

## Requirements
- R1: A stop request in the run state raises stop_o at the next clock edge, and cnt_o is 0 from that edge on.
- R2: While stopped, cnt_o holds its value and stop_o stays high until one of wake_irq_i, wake_brk_i or wake_rst_i is sampled high. Each of the three ends the stop alone.
- R3: If short_rec_i is 1 when a wake is sampled at edge k, recov_o is high with cnt_o = 0 after edge k. done_o is high after edge k+31, when cnt_o = 31, making a recovery of 32 cycles.
- R4: If short_rec_i is 0 when a wake is sampled at edge k, done_o is high after edge k+4095, when cnt_o = 4095, making a recovery of 4096 cycles.
- R5: short_rec_i is captured only at the wake edge. Changing it during recovery does not alter the cycle in which done_o fires.
- R6: done_o is high for exactly one cycle and only while recov_o is high. After it, recov_o and stop_o are low.
- R7: wake_rst_i never changes cnt_o. While running, the count still advances by 1 per cycle. When it wakes a stop, the count starts recovery from its held value of 0.
- R8: Outside stop, cnt_o increments by 1 every cycle and wraps from 4095 to 0.
- R9: Wake inputs sampled while in the run state are ignored: recov_o stays low and stop_o stays low.
- R10: A stop request during recovery is deferred. Recovery completes with done_o on schedule, and stop_o rises at the following edge with cnt_o = 0.
- R11: While rst_ni is low, stop_o, recov_o and done_o are 0 and cnt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| stop_req_i | input | 1 | Request to enter stop |
| wake_irq_i | input | 1 | Interrupt wake source |
| wake_brk_i | input | 1 | Break wake source |
| wake_rst_i | input | 1 | External reset wake source; does not touch the count |
| short_rec_i | input | 1 | 1 selects the short recovery delay, 0 the long one |
| stop_o | output | 1 | Stop state active |
| recov_o | output | 1 | Recovery delay running |
| done_o | output | 1 | One-cycle pulse on the last recovery cycle |
| cnt_o | output | 12 | Current counter value |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a long delay of 4096 and a short delay of 32. With these values both recovery lengths are checked to the exact cycle. The free-run wrap from 4095 to 0 is also reached within a short run. A scoreboard queue holds the cycle in which each done pulse is expected. These are checked under different wake sources, with the configuration bit flipped mid-recovery, and with a stop request deferred until recovery completes.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_RECOV = 2'd2
  } smr_state_e;
endpackage

// File: rtl/smr_cnt.sv
module smr_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // no external-reset input by design: only power-on and stop entry clear it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!hold_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/smr_dly_sel.sv
module smr_dly_sel #(
  parameter int CNT_W     = 12,
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             short_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DLY - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DLY - 1);

  logic short_q;
  logic [CNT_W-1:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     short_q <= 1'b0;
    else if (load_i) short_q <= short_i;
  end

  generate
    if (SHORT_DLY == LONG_DLY) begin : g_one_len
      assign last = LONG_LAST;
    end else begin : g_two_len
      assign last = short_q ? SHORT_LAST : LONG_LAST;
    end
  endgenerate

  assign hit_o = (cnt_i == last);

  initial begin
    a_r4_dly_fits: assert (LONG_DLY <= (1 << CNT_W) && SHORT_DLY >= 1);
  end
endmodule

// File: rtl/smr_seq.sv
module smr_seq
  import smr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_i,
  input  logic hit_i,
  output logic stop_o,
  output logic recov_o,
  output logic done_o,
  output logic clr_o,
  output logic hold_o,
  output logic load_o
);
  smr_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic done, go_stop;

  assign done    = (state_q == ST_RECOV) && hit_i;
  assign go_stop = ((state_q == ST_RUN) && stop_req_i) ||
                   (done && (pend_q || stop_req_i));

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_RUN:   if (stop_req_i) state_d = ST_STOP;
      ST_STOP:  if (wake_i)     state_d = ST_RECOV;
      ST_RECOV: begin
        if (done) begin
          state_d = go_stop ? ST_STOP : ST_RUN;
          pend_d  = 1'b0;
        end else if (stop_req_i) begin
          pend_d  = 1'b1;
        end
      end
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign stop_o  = (state_q == ST_STOP);
  assign recov_o = (state_q == ST_RECOV);
  assign done_o  = done;
  assign clr_o   = go_stop;
  assign hold_o  = (state_q == ST_STOP);
  assign load_o  = (state_q == ST_STOP) && wake_i;

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_stop_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !wake_i) |=> stop_o);
  a_r9_wake_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !stop_req_i) |=> state_q == ST_RUN);
  a_r10_defer_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_o && !done && stop_req_i) |=> pend_q);
  a_r6_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && recov_o));
endmodule

// File: rtl/stop_recov_timer.sv
module stop_recov_timer #(
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32,
  parameter int CNT_W     = $clog2(LONG_DLY)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_irq_i,
  input  logic             wake_brk_i,
  input  logic             wake_rst_i,
  input  logic             short_rec_i,
  output logic             stop_o,
  output logic             recov_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic wake_any, hit, clr, hold, load;

  // external reset acts only as a wake source here
  assign wake_any = wake_irq_i | wake_brk_i | wake_rst_i;

  smr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_any),
    .hit_i      (hit),
    .stop_o     (stop_o),
    .recov_o    (recov_o),
    .done_o     (done_o),
    .clr_o      (clr),
    .hold_o     (hold),
    .load_o     (load)
  );

  smr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .hold_i (hold),
    .cnt_o  (cnt_o)
  );

  smr_dly_sel #(
    .CNT_W     (CNT_W),
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
  ) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .short_i (short_rec_i),
    .cnt_i   (cnt_o),
    .hit_o   (hit)
  );

  a_r1_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> cnt_o == '0);
  a_r7_stop_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> cnt_o == $past(cnt_o));
  a_r3_recov_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_o && !done_o) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  a_r6_done_in_recov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> recov_o);
endmodule

// File: tb/sim_stop_recov_timer.sv
`timescale 1ns/1ps
module sim_stop_recov_timer;
  localparam int LONG  = 4096;
  localparam int SHORT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, w_irq = 1'b0, w_brk = 1'b0, w_rst = 1'b0, short_b = 1'b0;
  logic stop_a, recov_a, done_a;
  logic [11:0] cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fin = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stop_recov_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req),
    .wake_irq_i(w_irq), .wake_brk_i(w_brk), .wake_rst_i(w_rst),
    .short_rec_i(short_b), .stop_o(stop_a), .recov_o(recov_a),
    .done_o(done_a), .cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: each done pulse must match the next expected cycle (R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_n && done_a) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected done", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3/R4 done cycle", cyc, e);
      end
    end
  end

  // driver: wake at current negedge, push expected done cycle
  task automatic wake(input int src, input bit sh);
    short_b = sh;
    w_irq = (src == 0);
    w_brk = (src == 1);
    w_rst = (src == 2);
    exp_q.push_back(cyc + (sh ? SHORT : LONG));
    @(negedge clk);
    w_irq = 0; w_brk = 0; w_rst = 0;
  endtask

  task automatic enter_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  int c0;
  initial begin
    repeat (3) @(negedge clk);
    chk(stop_a == 0 && recov_a == 0 && done_a == 0, "R11 flags in reset", {stop_a, recov_a, done_a}, 0);
    chk(cnt == 0, "R11 count in reset", cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    c0 = cnt;
    @(negedge clk);
    chk(cnt == 12'(c0 + 1), "R8 free run", cnt, c0 + 1);

    // external reset and interrupt while running
    c0 = cnt;
    w_rst = 1'b1; w_irq = 1'b1;
    repeat (3) @(negedge clk);
    w_rst = 1'b0; w_irq = 1'b0;
    chk(cnt == 12'(c0 + 3), "R7 ext reset keeps counting", cnt, c0 + 3);
    chk(recov_a == 0 && stop_a == 0, "R9 wake ignored in run", {stop_a, recov_a}, 0);

    // stop, wake by external reset, short delay, bit flipped mid-run
    enter_stop();
    chk(stop_a == 1 && cnt == 0, "R1 stop entry clears count", cnt, 0);
    repeat (5) @(negedge clk);
    chk(stop_a == 1 && cnt == 0, "R2 stop holds count", cnt, 0);
    wake(2, 1'b1);
    chk(recov_a == 1 && cnt == 0, "R7 wake by ext reset keeps count", cnt, 0);
    short_b = 1'b0;
    repeat (SHORT - 1) @(negedge clk);
    chk(done_a == 1 && cnt == SHORT - 1, "R3 short done count", cnt, SHORT - 1);
    @(negedge clk);
    chk(recov_a == 0 && stop_a == 0 && done_a == 0, "R6 after done", {stop_a, recov_a, done_a}, 0);

    // stop, wake by interrupt, long delay, bit set mid-run
    enter_stop();
    wake(0, 1'b0);
    short_b = 1'b1;
    repeat (LONG - 1) @(negedge clk);
    chk(done_a == 1 && cnt == LONG - 1, "R4 long done count", cnt, LONG - 1);
    @(negedge clk);
    chk(recov_a == 0, "R5 long unaffected by bit change", recov_a, 0);
    chk(cnt == 0, "R8 wrap after 4095", cnt, 0);

    // stop, wake by break, stop request deferred during recovery
    enter_stop();
    wake(1, 1'b1);
    repeat (4) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(stop_a == 0 && recov_a == 1, "R10 stop held off", stop_a, 0);
    repeat (SHORT - 6) @(negedge clk);
    chk(done_a == 1, "R10 done on schedule", done_a, 1);
    @(negedge clk);
    chk(stop_a == 1 && cnt == 0, "R10 deferred stop entered", cnt, 0);
    wake(0, 1'b1);
    repeat (SHORT) @(negedge clk);
    chk(recov_a == 0 && stop_a == 0, "R2 irq ends stop", {stop_a, recov_a}, 0);

    // free-run wrap
    c0 = 0;
    while (cnt != 12'hFFF && c0 < 5000) begin @(negedge clk); c0++; end
    @(negedge clk);
    chk(cnt == 0, "R8 wrap to zero", cnt, 0);

    chk(exp_q.size() == 0, "R6 missing done pulses", exp_q.size(), 0);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule